// File: doc/BRIEF.md
# Raster Position Counters with Decoded Line and Frame Reset

This block produces the beam position for a composite-video game screen. It takes a fast oscillator clock and halves it with a two-state toggle machine to make a pixel clock with a 50% duty cycle. The whole design stays in the oscillator clock domain. The toggle machine also gives a one-cycle advance enable, which is high on the oscillator edge where the pixel clock rises. The machine has two states. `PH_LOW` (pixel clock low) moves to `PH_HIGH` on the advance edge. `PH_HIGH` (pixel clock high) moves back to `PH_LOW` on the next oscillator edge.

A horizontal counter steps once per pixel. A vertical counter steps once per line, using the horizontal reset as a clock enable. Each counter finds its terminal value with a partial decode: an AND of only those bits that are set in the last count. By default the last counts are 454 and 261. The decode is captured by a reset register on the next advance, and that register clears its counter. The reset register drives two copies of the clear. The active-low copy clears the most significant position bit. The active-high copy clears all the lower bits. While the reset is high the position reads zero, and on the following advance it reads one. The line is therefore 455 pixels long and the frame is 262 lines long.

Downstream logic uses the individual position bits to place objects on the screen. It also gets the complement of each counter's top bit, and the line and frame resets in both polarities.

Top module: `raster_timing`

## Requirements
- R1: `pix_clk` is low after reset and toggles on every oscillator edge. Both counters change only on the oscillator edge where `pix_clk` goes from 0 to 1.
- R2: `hpos` steps by one per pixel clock from 0 to `H_LAST` (454 by default). One pixel later it reads 0 again, so the line period is `H_LAST`+1 = 455 pixel clocks.
- R3: The line-end decode is the AND of only the bits that are 1 in `H_LAST` (by default bits 1, 2, 6, 7 and 8, the weights 2, 4, 64, 128 and 256). `hrst` rises one pixel after `hpos` reads `H_LAST` and stays high for exactly one pixel clock (two oscillator cycles). Successive rises are 455 pixel clocks apart.
- R4: While `hrst` is high, `hpos` reads 0. The active-low copy of the reset clears bit 8 and the active-high copy clears bits 7 to 0. On the pixel after the pulse, `hpos` reads 1.
- R5: `hrst_n` is always the inverse of `hrst`.
- R6: `vpos` changes only on the pixel edge that ends an `hrst` pulse, and then steps by one. It reads 0 while `vrst` is high and 1 on the line after.
- R7: The frame-end decode is the AND of the bits that are 1 in `V_LAST` (by default bits 0, 2 and 8, the count 261). `vrst` rises on the line after `vpos` reads `V_LAST` and covers exactly one line, which contains one `hrst` pulse. Successive rises are `V_LAST`+1 lines apart (262 by default).
- R8: `vrst_n` is always the inverse of `vrst`.
- R9: `hpos_top_n` and `vpos_top_n` are the inverses of the most significant bits of `hpos` and `vpos`.
- R10: A synchronous `rst` sets both positions to 0, deasserts both resets (`hrst`/`vrst` at 0, `hrst_n`/`vrst_n` at 1), and sets `pix_clk` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| pix_clk | output | 1 | Pixel clock, oscillator divided by two |
| hpos | output | H_W (9) | Horizontal position bits, weights 1 to 256 |
| hpos_top_n | output | 1 | Inverse of the top horizontal bit |
| hrst | output | 1 | Line reset, active high |
| hrst_n | output | 1 | Line reset, active low |
| vpos | output | V_W (9) | Vertical position bits, weights 1 to 256 |
| vpos_top_n | output | 1 | Inverse of the top vertical bit |
| vrst | output | 1 | Frame reset, active high |
| vrst_n | output | 1 | Frame reset, active low |

## Verification
Every output is due on the oscillator edge that ends `PH_LOW`. The first such edge after reset is the first one at which `rst` is low, and one occurs every two oscillator cycles after that. The position read while a reset register is high is due on that same edge, with no extra cycle. The vertical position moves one pixel edge after `hrst` rises. On each oscillator edge the scoreboard queues the values worked out from the number of edges since reset. The comparison happens at the following falling edge, so the expected values and the design outputs always refer to the same edge. Line and frame periods and pulse widths are measured separately, in oscillator cycles and in line pulses. To keep a whole frame inside the run, the bench uses a shorter frame (`V_LAST` = 21).

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int H_LAST_DEF = 454;
    localparam int V_LAST_DEF = 261;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

endpackage

// File: rtl/pix_divider.sv
module pix_divider
    import raster_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic pix_clk,
    output logic adv_en
);

    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  state_d = PH_HIGH;
            PH_HIGH: state_d = PH_LOW;
        endcase
    end

    always_comb begin
        pix_clk = 1'b0;
        adv_en  = 1'b0;
        unique case (state_q)
            PH_LOW:  adv_en  = 1'b1;
            PH_HIGH: pix_clk = 1'b1;
        endcase
    end

    a_r1_rise_after_low: assert property (@(posedge clk) disable iff (rst)
        !pix_clk |=> pix_clk);
    a_r1_fall_after_high: assert property (@(posedge clk) disable iff (rst)
        pix_clk |=> !pix_clk);

endmodule

// File: rtl/decoded_counter.sv
module decoded_counter #(
    parameter int LAST = 454,
    parameter int W    = $clog2(LAST + 2)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_en,
    output logic [W-1:0] cnt_o,
    output logic         top_n_o,
    output logic         rst_hi_o,
    output logic         rst_lo_o
);

    localparam logic [W-1:0] DEC_MASK = W'(LAST);

    logic [W-1:0] cnt_q;
    logic         rst_q;
    logic [W-1:0] shown;
    logic [W-1:0] term_bits;
    logic         term_hit;

    assign rst_hi_o = rst_q;
    assign rst_lo_o = ~rst_q;

    // top bit cleared by the active-low copy, lower bits by the active-high copy
    always_comb begin
        shown[W-1]   = cnt_q[W-1] & rst_lo_o;
        shown[W-2:0] = cnt_q[W-2:0] & {(W-1){~rst_hi_o}};
    end

    // partial decode: only bits set in the last count take part
    for (genvar i = 0; i < W; i++) begin : g_dec
        if (DEC_MASK[i]) begin : g_use
            assign term_bits[i] = shown[i];
        end else begin : g_skip
            assign term_bits[i] = 1'b1;
        end
    end
    assign term_hit = &term_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rst_q <= 1'b0;
        end else if (adv_en) begin
            rst_q <= term_hit;
            cnt_q <= rst_q ? W'(1) : cnt_q + W'(1);
        end
    end

    assign cnt_o   = shown;
    assign top_n_o = ~shown[W-1];

    a_r2_within_range: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= DEC_MASK);
    a_r3_pulse_after_last: assert property (@(posedge clk) disable iff (rst)
        (adv_en && cnt_o == DEC_MASK) |=> (rst_hi_o && cnt_o == '0));
    a_r4_release_to_one: assert property (@(posedge clk) disable iff (rst)
        (adv_en && rst_hi_o) |=> (!rst_hi_o && cnt_o == W'(1)));
    a_r1_hold_between: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> ($stable(cnt_o) && $stable(rst_hi_o)));

endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
#(
    parameter int H_LAST = H_LAST_DEF,
    parameter int V_LAST = V_LAST_DEF,
    parameter int H_W    = $clog2(H_LAST + 2),
    parameter int V_W    = $clog2(V_LAST + 2)
) (
    input  logic           clk_osc,
    input  logic           rst,
    output logic           pix_clk,
    output logic [H_W-1:0] hpos,
    output logic           hpos_top_n,
    output logic           hrst,
    output logic           hrst_n,
    output logic [V_W-1:0] vpos,
    output logic           vpos_top_n,
    output logic           vrst,
    output logic           vrst_n
);

    logic pix_adv;
    logic line_adv;

    pix_divider u_div (
        .clk     (clk_osc),
        .rst     (rst),
        .pix_clk (pix_clk),
        .adv_en  (pix_adv)
    );

    decoded_counter #(.LAST(H_LAST), .W(H_W)) u_hcnt (
        .clk      (clk_osc),
        .rst      (rst),
        .adv_en   (pix_adv),
        .cnt_o    (hpos),
        .top_n_o  (hpos_top_n),
        .rst_hi_o (hrst),
        .rst_lo_o (hrst_n)
    );

    // line reset used as a clock enable, not as a clock
    assign line_adv = pix_adv & hrst;

    decoded_counter #(.LAST(V_LAST), .W(V_W)) u_vcnt (
        .clk      (clk_osc),
        .rst      (rst),
        .adv_en   (line_adv),
        .cnt_o    (vpos),
        .top_n_o  (vpos_top_n),
        .rst_hi_o (vrst),
        .rst_lo_o (vrst_n)
    );

    a_r6_vpos_only_at_line_end: assert property (@(posedge clk_osc) disable iff (rst)
        !(pix_adv && hrst) |=> $stable(vpos));
    a_r6_step_at_line_end: assert property (@(posedge clk_osc) disable iff (rst)
        (pix_adv && hrst && !vrst && vpos != V_W'(V_LAST)) |=> (vpos == $past(vpos) + V_W'(1)));
    a_r4_zero_in_pulse: assert property (@(posedge clk_osc) disable iff (rst)
        hrst |-> (hpos == '0));

endmodule

// File: tb/test_raster_timing.sv
module test_raster_timing;

    localparam int CLK_PERIOD = 10;
    localparam int H_LAST     = 454;
    localparam int V_LAST     = 21;
    localparam int H_W        = $clog2(H_LAST + 2);
    localparam int V_W        = $clog2(V_LAST + 2);
    localparam int HP         = H_LAST + 1;
    localparam int VP         = V_LAST + 1;
    localparam int RUN_EDGES  = 2 * HP * VP * 2 + 2 * HP * 3;

    typedef struct packed {
        logic         pix;
        logic [H_W-1:0] h;
        logic         hr;
        logic [V_W-1:0] v;
        logic         vr;
    } exp_t;

    logic           clk_osc = 1'b0;
    logic           rst     = 1'b1;
    logic           pix_clk;
    logic [H_W-1:0] hpos;
    logic           hpos_top_n;
    logic           hrst;
    logic           hrst_n;
    logic [V_W-1:0] vpos;
    logic           vpos_top_n;
    logic           vrst;
    logic           vrst_n;

    int   checks   = 0;
    int   failures = 0;
    bit   run      = 1'b0;
    int   k        = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk_osc = ~clk_osc;

    raster_timing #(.H_LAST(H_LAST), .V_LAST(V_LAST)) i_raster_timing (
        .clk_osc    (clk_osc),
        .rst        (rst),
        .pix_clk    (pix_clk),
        .hpos       (hpos),
        .hpos_top_n (hpos_top_n),
        .hrst       (hrst),
        .hrst_n     (hrst_n),
        .vpos       (vpos),
        .vpos_top_n (vpos_top_n),
        .vrst       (vrst),
        .vrst_n     (vrst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at edge %0d: got %0d expected %0d", req, k, act, exp);
        end
    endtask

    function automatic exp_t expect_at(input int edges);
        exp_t e;
        int p;
        int line;
        p     = (edges + 1) / 2;
        line  = (p == 0) ? 0 : (p - 1) / HP;
        e.pix = (edges % 2 == 1);
        e.h   = H_W'(p % HP);
        e.hr  = (p > 0) && (p % HP == 0);
        e.v   = V_W'(line % VP);
        e.vr  = (line > 0) && (line % VP == 0);
        return e;
    endfunction

    // driver side: one expected item per oscillator edge
    always @(posedge clk_osc) begin
        if (run) begin
            k++;
            sb_q.push_back(expect_at(k));
        end
    end

    int  last_hrise = -1;
    int  hwidth     = 0;
    int  lines_seen = 0;
    int  last_vrise = -1;
    int  vr_lines   = 0;
    bit  prev_hr    = 1'b0;
    bit  prev_vr    = 1'b0;

    // monitor side: compare at the falling edge after each driver push
    always @(negedge clk_osc) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(pix_clk == e.pix, "R1 pix_clk", pix_clk, e.pix);
            chk(hpos == e.h, "R2 hpos", hpos, e.h);
            chk(hrst == e.hr, "R3 hrst", hrst, e.hr);
            if (e.hr) chk(hpos == '0, "R4 hpos zero in pulse", hpos, 0);
            chk(hrst_n == !hrst, "R5 hrst_n", hrst_n, !hrst);
            chk(vpos == e.v, "R6 vpos", vpos, e.v);
            chk(vrst == e.vr, "R7 vrst", vrst, e.vr);
            chk(vrst_n == !vrst, "R8 vrst_n", vrst_n, !vrst);
            chk(hpos_top_n == !hpos[H_W-1], "R9 hpos_top_n", hpos_top_n, !hpos[H_W-1]);
            chk(vpos_top_n == !vpos[V_W-1], "R9 vpos_top_n", vpos_top_n, !vpos[V_W-1]);

            if (hrst && !prev_hr) begin
                if (last_hrise >= 0)
                    chk(k - last_hrise == 2 * HP, "R3 line period", k - last_hrise, 2 * HP);
                last_hrise = k;
                lines_seen++;
                if (vrst) vr_lines++;
                hwidth = 0;
            end
            if (hrst) hwidth++;
            if (!hrst && prev_hr) chk(hwidth == 2, "R3 pulse width", hwidth, 2);

            if (vrst && !prev_vr) begin
                if (last_vrise >= 0)
                    chk(lines_seen - last_vrise == VP, "R7 frame period", lines_seen - last_vrise, VP);
                last_vrise = lines_seen;
                vr_lines   = 0;
            end
            if (!vrst && prev_vr) chk(vr_lines == 1, "R7 frame pulse one line", vr_lines, 1);
            prev_hr = hrst;
            prev_vr = vrst;
        end
    end

    task automatic check_reset_state();
        chk(pix_clk == 1'b0, "R10 pix_clk", pix_clk, 0);
        chk(hpos == '0, "R10 hpos", hpos, 0);
        chk(vpos == '0, "R10 vpos", vpos, 0);
        chk(hrst == 1'b0 && hrst_n == 1'b1, "R10 hrst", hrst, 0);
        chk(vrst == 1'b0 && vrst_n == 1'b1, "R10 vrst", vrst, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: run did not end, got %0d edges expected %0d", k, RUN_EDGES);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk_osc);
        @(negedge clk_osc);
        check_reset_state();
        rst = 1'b0;
        run = 1'b1;
        repeat (RUN_EDGES) @(negedge clk_osc);
        run = 1'b0;
        @(negedge clk_osc);
        chk(last_vrise >= 0, "R7 frame pulse seen", last_vrise, 1);
        rst = 1'b1;
        @(negedge clk_osc);
        check_reset_state();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule